// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides, for the instruction currently in the execute stage of a five-stage in-order pipeline, where each of its two ALU source operands should come from. It compares the two source register numbers held in the decode-to-execute stage register with the destination register numbers and write enables of the two older instructions. Those older instructions sit in the execute-to-memory and memory-to-writeback stage registers. If an older instruction is about to write a source register, its value is taken from the pipeline rather than from the register file. If both older instructions write the same register, the younger one wins.

The forwarding decision is a purely combinational control module. A datapath module around it models the three stage registers, a small register file written at writeback and read in execute, and the operand multiplexers. Whole instruction sequences can therefore be streamed in, one instruction per clock, and the resolved operand values read out. Each instruction is described by its source registers, its destination register, a write enable and the value it produces. A cleared write enable acts as a bubble or a non-writing instruction.

Top module: `fwd_top`

## Requirements
- R1: When the instruction one ahead (execute-to-memory stage) has its write enable set, a nonzero destination, and a destination equal to the execute-stage first source, `selA` is 2'b10 and `opA` carries that instruction's result.
- R2: When only the instruction two ahead (memory-to-writeback stage) writes a nonzero destination equal to the first source, `selA` is 2'b01 and `opA` carries that older result.
- R3: When both older instructions write the first source register, `selA` is 2'b10 and `opA` is the younger instruction's result.
- R4: Destination register 0 never causes forwarding, and a source of register 0 always reads as zero with select 2'b00.
- R5: An older instruction whose write enable is clear never causes forwarding, even when its destination matches.
- R6: The second operand (`selB`, `opB`, source `instrRt`) follows the same rules as the first, independently of it.
- R7: With no forwarding (select 2'b00), the operand is the register-file value. An instruction three or more slots ahead has already written the register file, so every operand equals the value of the most recent writer in program order.
- R8: While `rstN` is low, all stage write enables and all registers are cleared, so both selects read 2'b00 and both operands read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrWr | input | 1 | Issued instruction writes its destination register |
| instrDst | input | 5 | Destination register of the issued instruction |
| instrRs | input | 5 | First source register of the issued instruction |
| instrRt | input | 5 | Second source register of the issued instruction |
| instrResult | input | 32 | Value the issued instruction produces |
| selA | output | 2 | First-operand source select: 00 register file, 10 one ahead, 01 two ahead |
| selB | output | 2 | Second-operand source select, same encoding |
| opA | output | 32 | Resolved first operand of the execute-stage instruction |
| opB | output | 32 | Resolved second operand of the execute-stage instruction |

## Verification
The hardest situation to reach is a double hazard in which the younger candidate must win. A second, subtler case has the younger instruction match the register number but be disqualified by a zero destination or a cleared write enable, so the older match must still be taken. Directed sequences of three back-to-back writers to one register reach the first case. Writer, non-writer and reader triples reach the second. A long pseudo-random stream confined to four registers then produces every mix of distance-one, distance-two and register-file dependences, checked against a program-order model of the architectural registers.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwdSel_t;

  typedef struct packed {
    fwdSel_t selA;
    fwdSel_t selB;
  } fwdStrobes_t;
endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int REG_BITS = 5
) (
  input  logic [REG_BITS-1:0] exRs,
  input  logic [REG_BITS-1:0] exRt,
  input  logic                memWr,
  input  logic [REG_BITS-1:0] memDst,
  input  logic                wbWr,
  input  logic [REG_BITS-1:0] wbDst,
  output fwdStrobes_t         strobes
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_BITS-1:0] srcReg;
  logic [NUM_SRC-1:0][1:0]          selVec;
  logic memLive;
  logic wbLive;

  assign srcReg[0] = exRs;
  assign srcReg[1] = exRt;

  // An older stage is a forwarding candidate only if it really writes a
  // register other than the hardwired zero register.
  assign memLive = memWr && (memDst != '0);
  assign wbLive  = wbWr  && (wbDst  != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic memHit;
    logic wbHit;
    assign memHit = memLive && (memDst == srcReg[g]);
    // The older stage only applies when the younger one does not match.
    assign wbHit  = wbLive && (wbDst == srcReg[g]) && !memHit;
    assign selVec[g] = memHit ? SEL_MEM : (wbHit ? SEL_WB : SEL_RF);
  end

  assign strobes.selA = fwdSel_t'(selVec[0]);
  assign strobes.selB = fwdSel_t'(selVec[1]);
endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int REG_BITS  = 5,
  parameter int DATA_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instrWr,
  input  logic [REG_BITS-1:0]  instrDst,
  input  logic [REG_BITS-1:0]  instrRs,
  input  logic [REG_BITS-1:0]  instrRt,
  input  logic [DATA_BITS-1:0] instrResult,
  input  fwdStrobes_t          strobes,
  output logic [REG_BITS-1:0]  exRs,
  output logic [REG_BITS-1:0]  exRt,
  output logic                 memWr,
  output logic [REG_BITS-1:0]  memDst,
  output logic                 wbWr,
  output logic [REG_BITS-1:0]  wbDst,
  output logic [DATA_BITS-1:0] opA,
  output logic [DATA_BITS-1:0] opB
);
  localparam int NUM_REGS = 1 << REG_BITS;
  localparam int NUM_SRC  = 2;

  // decode-to-execute stage
  logic                 exWr;
  logic [REG_BITS-1:0]  exDst;
  logic [DATA_BITS-1:0] exRes;
  // execute-to-memory stage
  logic [DATA_BITS-1:0] memRes;
  // memory-to-writeback stage
  logic [DATA_BITS-1:0] wbRes;

  logic [DATA_BITS-1:0] regFile [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exWr   <= 1'b0;
      exDst  <= '0;
      exRs   <= '0;
      exRt   <= '0;
      exRes  <= '0;
      memWr  <= 1'b0;
      memDst <= '0;
      memRes <= '0;
      wbWr   <= 1'b0;
      wbDst  <= '0;
      wbRes  <= '0;
    end else begin
      exWr   <= instrWr;
      exDst  <= instrDst;
      exRs   <= instrRs;
      exRt   <= instrRt;
      exRes  <= instrResult;
      memWr  <= exWr;
      memDst <= exDst;
      memRes <= exRes;
      wbWr   <= memWr;
      wbDst  <= memDst;
      wbRes  <= memRes;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else if (wbWr && (wbDst != '0)) begin
      regFile[wbDst] <= wbRes;
    end
  end

  logic [NUM_SRC-1:0][REG_BITS-1:0]  srcReg;
  logic [NUM_SRC-1:0][1:0]           srcSel;
  logic [NUM_SRC-1:0][DATA_BITS-1:0] srcVal;

  assign srcReg[0] = exRs;
  assign srcReg[1] = exRt;
  assign srcSel[0] = strobes.selA;
  assign srcSel[1] = strobes.selB;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gMux
    logic [DATA_BITS-1:0] rfVal;
    assign rfVal = (srcReg[g] == '0) ? '0 : regFile[srcReg[g]];
    always_comb begin
      case (srcSel[g])
        SEL_MEM: srcVal[g] = memRes;
        SEL_WB:  srcVal[g] = wbRes;
        default: srcVal[g] = rfVal;
      endcase
    end
  end

  assign opA = srcVal[0];
  assign opB = srcVal[1];
endmodule

// File: rtl/fwd_top.sv
module fwd_top
  import fwd_pkg::*;
#(
  parameter int REG_BITS  = 5,
  parameter int DATA_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instrWr,
  input  logic [REG_BITS-1:0]  instrDst,
  input  logic [REG_BITS-1:0]  instrRs,
  input  logic [REG_BITS-1:0]  instrRt,
  input  logic [DATA_BITS-1:0] instrResult,
  output logic [1:0]           selA,
  output logic [1:0]           selB,
  output logic [DATA_BITS-1:0] opA,
  output logic [DATA_BITS-1:0] opB
);
  fwdStrobes_t         strobes;
  logic [REG_BITS-1:0] exRs;
  logic [REG_BITS-1:0] exRt;
  logic                memWr;
  logic [REG_BITS-1:0] memDst;
  logic                wbWr;
  logic [REG_BITS-1:0] wbDst;

  fwd_ctrl #(.REG_BITS(REG_BITS)) uCtrl (
    .exRs    (exRs),
    .exRt    (exRt),
    .memWr   (memWr),
    .memDst  (memDst),
    .wbWr    (wbWr),
    .wbDst   (wbDst),
    .strobes (strobes)
  );

  fwd_datapath #(.REG_BITS(REG_BITS), .DATA_BITS(DATA_BITS)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .instrWr     (instrWr),
    .instrDst    (instrDst),
    .instrRs     (instrRs),
    .instrRt     (instrRt),
    .instrResult (instrResult),
    .strobes     (strobes),
    .exRs        (exRs),
    .exRt        (exRt),
    .memWr       (memWr),
    .memDst      (memDst),
    .wbWr        (wbWr),
    .wbDst       (wbDst),
    .opA         (opA),
    .opB         (opB)
  );

  assign selA = strobes.selA;
  assign selB = strobes.selB;
endmodule

// File: rtl/fwd_checker.sv
module fwd_checker #(
  parameter int REG_BITS  = 5,
  parameter int DATA_BITS = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [DATA_BITS-1:0] instrResult,
  input logic [REG_BITS-1:0]  exRs,
  input logic [REG_BITS-1:0]  exRt,
  input logic                 memWr,
  input logic [REG_BITS-1:0]  memDst,
  input logic                 wbWr,
  input logic [REG_BITS-1:0]  wbDst,
  input logic [1:0]           selA,
  input logic [1:0]           selB,
  input logic [DATA_BITS-1:0] opA,
  input logic [DATA_BITS-1:0] opB
);
  assert_mem_value_R1: assert property (@(posedge clk) disable iff (!rstN)
    (selA == 2'b10) |-> (opA == $past(instrResult, 2)));

  assert_wb_value_R2: assert property (@(posedge clk) disable iff (!rstN)
    (selA == 2'b01) |-> (opA == $past(instrResult, 3)));

  assert_double_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && wbWr && memDst != '0 && memDst == wbDst && exRs == memDst)
      |-> (selA == 2'b10));

  assert_zero_src_R4: assert property (@(posedge clk) disable iff (!rstN)
    (exRs == '0) |-> (opA == '0 && selA == 2'b00));

  assert_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!memWr && !wbWr) |-> (selA == 2'b00 && selB == 2'b00));

  assert_second_src_R6: assert property (@(posedge clk) disable iff (!rstN)
    (selB == 2'b10) |-> (opB == $past(instrResult, 2)));

  assert_legal_sel_R6: assert property (@(posedge clk) disable iff (!rstN)
    (selA != 2'b11) && (selB != 2'b11));

  assert_zero_src_b_R4: assert property (@(posedge clk) disable iff (!rstN)
    (exRt == '0) |-> (opB == '0));
endmodule

bind fwd_top fwd_checker #(.REG_BITS(REG_BITS), .DATA_BITS(DATA_BITS)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .instrResult (instrResult),
  .exRs        (exRs),
  .exRt        (exRt),
  .memWr       (memWr),
  .memDst      (memDst),
  .wbWr        (wbWr),
  .wbDst       (wbDst),
  .selA        (selA),
  .selB        (selB),
  .opA         (opA),
  .opB         (opB)
);

// File: tb/tb_fwd_top.sv
module tb_fwd_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrWr = 1'b0;
  logic [4:0]  instrDst = '0;
  logic [4:0]  instrRs = '0;
  logic [4:0]  instrRt = '0;
  logic [31:0] instrResult = '0;
  logic [1:0]  selA;
  logic [1:0]  selB;
  logic [31:0] opA;
  logic [31:0] opB;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fwd_top dut (
    .clk(clk), .rstN(rstN), .instrWr(instrWr), .instrDst(instrDst),
    .instrRs(instrRs), .instrRt(instrRt), .instrResult(instrResult),
    .selA(selA), .selB(selB), .opA(opA), .opB(opB)
  );

  typedef struct packed {
    logic [1:0]  sa;
    logic [1:0]  sb;
    logic [31:0] va;
    logic [31:0] vb;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];

  // program-order model of the architectural registers
  logic [31:0] arch [32];
  logic        p1Wr, p2Wr;
  logic [4:0]  p1Dst, p2Dst;

  task automatic check(string tag, bit ok, logic [71:0] act, logic [71:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] expSel(logic [4:0] src);
    if (p1Wr && p1Dst != 0 && p1Dst == src) return 2'b10;
    if (p2Wr && p2Dst != 0 && p2Dst == src) return 2'b01;
    return 2'b00;
  endfunction

  task automatic issue(bit wr, logic [4:0] dst, logic [4:0] rs, logic [4:0] rt,
                       logic [31:0] res, string tag);
    expItem_t e;
    @(negedge clk);
    instrWr = wr; instrDst = dst; instrRs = rs; instrRt = rt; instrResult = res;
    e.sa = expSel(rs);
    e.sb = expSel(rt);
    e.va = arch[rs];
    e.vb = arch[rt];
    expQ.push_back(e);
    tagQ.push_back(tag);
    if (wr && dst != 0) arch[dst] = res;
    p2Wr = p1Wr; p2Dst = p1Dst;
    p1Wr = wr;   p1Dst = dst;
  endtask

  // monitor: instruction driven before edge k is in execute after edge k
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, selA == e.sa && selB == e.sb && opA == e.va && opB == e.vb,
              {selA, selB, opA, opB}, {e.sa, e.sb, e.va, e.vb});
      end
    end
  end

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 32; i++) arch[i] = '0;
    p1Wr = 0; p2Wr = 0; p1Dst = 0; p2Dst = 0;
    repeat (3) @(negedge clk);
    // R8: reset state while held in reset
    check("R8 reset", selA == 0 && selB == 0 && opA == 0 && opB == 0,
          {selA, selB, opA, opB}, 72'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R1, R3: three back-to-back writers to r1, then readers
    issue(1, 1, 0, 0, 32'h0000_0011, "R1 w1");
    issue(1, 1, 1, 0, 32'h0000_0022, "R1 dist1");
    issue(1, 1, 1, 1, 32'h0000_0033, "R3 double");
    issue(0, 0, 1, 1, 32'h0,         "R3 double read");
    // R2: writer, bubble, reader
    issue(1, 2, 0, 0, 32'hAAAA_0002, "R2 w2");
    issue(0, 2, 0, 0, 32'hDEAD_0000, "R5 bubble");
    issue(0, 0, 2, 0, 32'h0,         "R2 dist2");
    // R7: writer, two bubbles, reader from register file
    issue(1, 3, 0, 0, 32'h3333_3333, "R7 w3");
    issue(0, 0, 0, 0, 32'h0,         "R7 gap");
    issue(0, 0, 0, 0, 32'h0,         "R7 gap");
    issue(0, 0, 3, 3, 32'h0,         "R7 rf read");
    // R4: writes to r0 never forward and r0 reads zero
    issue(1, 0, 0, 0, 32'hFFFF_FFFF, "R4 w0");
    issue(1, 0, 0, 0, 32'hEEEE_EEEE, "R4 w0 again");
    issue(0, 0, 0, 0, 32'h0,         "R4 read r0");
    // R5: non-writing instruction with matching destination over an older writer
    issue(1, 4, 0, 0, 32'h4444_0001, "R5 w4");
    issue(0, 4, 0, 0, 32'h4444_9999, "R5 nowrite");
    issue(0, 0, 4, 4, 32'h0,         "R5 takes older");
    // R4: zero-destination younger over real older writer of r5
    issue(1, 5, 0, 0, 32'h5555_0005, "R4 w5");
    issue(1, 0, 0, 0, 32'h0BAD_0BAD, "R4 w0 mid");
    issue(0, 0, 5, 0, 32'h0,         "R4 older wins");
    // R6: independent operand selects
    issue(1, 6, 0, 0, 32'h6666_0006, "R6 w6");
    issue(1, 7, 0, 0, 32'h7777_0007, "R6 w7");
    issue(0, 0, 6, 7, 32'h0,         "R6 split");
    issue(0, 0, 7, 6, 32'h0,         "R6 split swap");
    // R7: pseudo-random stream over registers 0..3
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      logic [15:0] r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = lfsr;
      issue(r[0] | r[1], {3'b0, r[3:2]}, {3'b0, r[5:4]}, {3'b0, r[7:6]},
            {r, 16'(n)}, "R7 random");
    end
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule